// File: doc/BRIEF.md
# Oversampled I2C Slave Address Receiver

This block is the address front end of an I2C slave that runs entirely from an internal system clock, never from SCL. A programmable prescaler turns the system clock into a sampling tick. SCL and SDA are synchronised and edge-detected on that tick. A START condition raises a maskable start flag. A fixed wait of four ticks then follows before the block declares the bus busy and arms its 7-bit address shift register.

Once armed, the block shifts in seven address bits and the direction bit, MSB first, on rising SCL. It compares the address against a programmable own address and, when enabled, against the general-call address of all zeros. On a hit, it pulls SDA low for the ninth clock and sets the matching flag. On a miss, it lets go of the bus until the next START or STOP.

The arming delay is measured in prescaled ticks. A sampling clock that is too slow for the SCL rate therefore makes the slave lose the first address bits, and it will not acknowledge even a correct address. A host configures the block with the enable low, then raises the enable and polls or clears the three flags.

Top module: `i2c_addr_slave`

## Requirements
- R1: The prescaler divides the system clock by `cfg_psc + 1`, so a field of 0 samples the bus on every cycle and a field of 3 samples it every fourth cycle.
- R2: An SDA fall while SCL is high is a START. It sets `start_flag` within three tick periods of the SDA edge, but only while `start_ie` is 1. With `start_ie` at 0 the flag stays 0.
- R3: `bus_busy` rises exactly four ticks after the tick on which START is acted on. It is still low 6·(cfg_psc+1) cycles after the SDA fall and is high by 7·(cfg_psc+1) cycles.
- R4: SCL rising edges that arrive before arming are not shifted in. With a slow tick and fast SCL, a correct own address gets no ACK. The same address with slower SCL is acknowledged.
- R5: When the 7 received address bits equal the own address, `sda_oe` is 1 throughout the high phase of the ninth SCL clock and `oa_flag` is set. Both events happen together at the eighth SCL fall, and `sda_oe` is released after the ninth SCL fall.
- R6: The own address is taken from `cfg_oa[6:0]`. Bits 15 to 7 have no effect on matching.
- R7: Address 0000000 is acknowledged and sets `gc_flag` only when `gc_en` is 1. With `gc_en` at 0 it gets no ACK and no flag, provided the own address is nonzero.
- R8: A non-matching address gets no ACK and sets neither address flag. `bus_busy` stays high until STOP.
- R9: An SDA rise while SCL is high is a STOP and clears `bus_busy`. Out of reset, all flags, `bus_busy` and `sda_oe` are 0.
- R10: `cfg_we` loads the prescale and own address only while `enable` is 0. A write while enabled is ignored. Dropping `enable` returns the block to idle with `bus_busy` and `sda_oe` low.
- R11: `rw_dir` holds the eighth received bit, which is the R/W bit, captured on an acknowledged address.
- R12: Pulsing `flag_clr` clears flags by bit: bit 0 clears `start_flag`, bit 1 clears `oa_flag` and bit 2 clears `gc_flag`. If a clear and a set of the same flag fall in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; configuration writes need it low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_psc | input | 8 | Prescale field, divisor is value + 1 |
| cfg_oa | input | 16 | Own address, bits 6:0 used |
| start_ie | input | 1 | Enable for the start flag |
| gc_en | input | 1 | Enable for general-call recognition |
| flag_clr | input | 3 | Per-flag clear: bit 0 start, bit 1 own address, bit 2 general call |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| start_flag | output | 1 | START seen |
| oa_flag | output | 1 | Own address acknowledged |
| gc_flag | output | 1 | General call acknowledged |
| bus_busy | output | 1 | Bus busy, address receiver armed |
| rw_dir | output | 1 | R/W bit of the acknowledged address |

## Verification
Two events can land on the same clock edge: a software clear of `start_flag` and the hardware setting it for a new START. With the prescaler at divide-by-one, the bench holds the start clear bit high from the SDA fall through the third following edge. That third edge is the one on which the START is acted on. Once the clear is released, the flag must read 1, because the set takes priority over the clear.

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave #(
  parameter int PSC_W     = 8,
  parameter int OA_W      = 16,
  parameter int ARM_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic [PSC_W-1:0] cfg_psc,
  input  logic [OA_W-1:0]  cfg_oa,
  input  logic             start_ie,
  input  logic             gc_en,
  input  logic [2:0]       flag_clr,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic             start_flag,
  output logic             oa_flag,
  output logic             gc_flag,
  output logic             bus_busy,
  output logic             rw_dir
);
  localparam int WC_W = $clog2(ARM_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_ADDR, S_ACK, S_SKIP} st_t;

  st_t              state;
  logic [PSC_W-1:0] psc_r, pcnt;
  logic [6:0]       oa_r;
  logic [WC_W-1:0]  wcnt;
  logic [3:0]       bcnt;
  logic [7:0]       sr;
  logic             scl_s1, scl_s2, scl_q, sda_s1, sda_s2, sda_q;
  logic             unused_oa_hi;

  assign unused_oa_hi = ^cfg_oa[OA_W-1:7];

  wire tick    = enable && (pcnt == psc_r);
  wire start_c = scl_s2 & scl_q & sda_q & ~sda_s2;
  wire stop_c  = scl_s2 & scl_q & ~sda_q & sda_s2;
  wire scl_up  = scl_s2 & ~scl_q;
  wire scl_dn  = ~scl_s2 & scl_q;
  wire own_hit = (sr[7:1] == oa_r);
  wire gc_hit  = gc_en && (sr[7:1] == 7'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      psc_r <= '0;
      oa_r  <= '0;
    end else if (cfg_we && !enable) begin
      psc_r <= cfg_psc;
      oa_r  <= cfg_oa[6:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pcnt <= '0;
      {scl_s1, scl_s2, scl_q, sda_s1, sda_s2, sda_q} <= '1;
    end else if (!enable) begin
      pcnt <= '0;
      {scl_s1, scl_s2, scl_q, sda_s1, sda_s2, sda_q} <= '1;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) begin
        scl_s1 <= scl_in;  scl_s2 <= scl_s1;  scl_q <= scl_s2;
        sda_s1 <= sda_in;  sda_s2 <= sda_s1;  sda_q <= sda_s2;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= S_IDLE;
      wcnt       <= '0;
      bcnt       <= '0;
      sr         <= '0;
      sda_oe     <= 1'b0;
      bus_busy   <= 1'b0;
      rw_dir     <= 1'b0;
      start_flag <= 1'b0;
      oa_flag    <= 1'b0;
      gc_flag    <= 1'b0;
    end else begin
      start_flag <= start_flag & ~flag_clr[0];
      oa_flag    <= oa_flag    & ~flag_clr[1];
      gc_flag    <= gc_flag    & ~flag_clr[2];
      if (!enable) begin
        state    <= S_IDLE;
        sda_oe   <= 1'b0;
        bus_busy <= 1'b0;
      end else if (tick) begin
        if (stop_c) begin
          state    <= S_IDLE;
          sda_oe   <= 1'b0;
          bus_busy <= 1'b0;
        end else if (start_c) begin
          state  <= S_WAIT;
          wcnt   <= '0;
          sda_oe <= 1'b0;
          if (start_ie) start_flag <= 1'b1;
        end else begin
          case (state)
            S_WAIT:
              if (wcnt == WC_W'(ARM_TICKS - 1)) begin
                state    <= S_ADDR;
                bus_busy <= 1'b1;
                bcnt     <= '0;
              end else wcnt <= wcnt + 1'b1;
            S_ADDR: begin
              if (scl_up && bcnt < 4'd8) begin
                sr   <= {sr[6:0], sda_s2};
                bcnt <= bcnt + 1'b1;
              end
              if (scl_dn && bcnt == 4'd8) begin
                if (own_hit || gc_hit) begin
                  state  <= S_ACK;
                  sda_oe <= 1'b1;
                  rw_dir <= sr[0];
                  if (own_hit) oa_flag <= 1'b1;
                  else         gc_flag <= 1'b1;
                end else state <= S_SKIP;
              end
            end
            S_ACK:
              if (scl_dn) begin
                sda_oe <= 1'b0;
                state  <= S_SKIP;
              end
            default: ;
          endcase
        end
      end
    end
endmodule

module i2c_addr_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       start_ie,
  input logic       gc_en,
  input logic       sda_oe,
  input logic       start_flag,
  input logic       oa_flag,
  input logic       gc_flag,
  input logic       bus_busy,
  input logic [6:0] oa_r
);
  assert_ack_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> bus_busy);
  assert_oa_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oa_flag) |-> sda_oe);
  assert_gc_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc_flag) |-> (gc_en && sda_oe));
  assert_start_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_flag) |-> $past(start_ie));
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(oa_r));
  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bus_busy && !sda_oe));
endmodule

bind i2c_addr_slave i2c_addr_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .start_ie(start_ie), .gc_en(gc_en),
  .sda_oe(sda_oe), .start_flag(start_flag), .oa_flag(oa_flag), .gc_flag(gc_flag),
  .bus_busy(bus_busy), .oa_r(oa_r)
);

// File: tb/i2c_addr_slave_bench.sv
module i2c_addr_slave_bench;
  logic clk = 0, rst_n = 0, enable = 0, cfg_we = 0, start_ie = 1, gc_en = 1;
  logic [7:0]  cfg_psc = 0;
  logic [15:0] cfg_oa = 0;
  logic [2:0]  flag_clr = 0;
  logic m_scl = 1, m_sda = 1;
  logic sda_oe, start_flag, oa_flag, gc_flag, bus_busy, rw_dir;
  wire  sda_line = m_sda & ~sda_oe;

  int checks = 0, fails = 0, div = 1;
  bit finished = 0;
  logic obs_ack;

  typedef struct packed { logic ack, oa, gc, rw, st; } exp_t;
  exp_t exp_q[$];
  event done_ev;

  always #10 clk = ~clk;

  i2c_addr_slave u_i2c_addr_slave (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we), .cfg_psc(cfg_psc),
    .cfg_oa(cfg_oa), .start_ie(start_ie), .gc_en(gc_en), .flag_clr(flag_clr),
    .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe), .start_flag(start_flag),
    .oa_flag(oa_flag), .gc_flag(gc_flag), .bus_busy(bus_busy), .rw_dir(rw_dir)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(logic [7:0] psc, logic [15:0] oa);
    @(negedge clk); enable = 0; cfg_we = 1; cfg_psc = psc; cfg_oa = oa;
    @(negedge clk); cfg_we = 0; enable = 1; div = psc + 1;
    wait_cyc(4);
  endtask

  task automatic clear_flags();
    flag_clr = 3'b111; wait_cyc(1); flag_clr = 0;
    chk("R12", "flags after clear", {start_flag, oa_flag, gc_flag}, 3'b000);
  endtask

  task automatic txn(logic [6:0] addr, logic rw, int h, int d, logic e_ack, logic e_oa, logic e_gc);
    exp_t it;
    it.ack = e_ack; it.oa = e_oa; it.gc = e_gc; it.rw = rw; it.st = start_ie;
    exp_q.push_back(it);
    m_sda = 0; wait_cyc(d); m_scl = 0;
    for (int i = 0; i < 8; i++) begin
      wait_cyc(2); m_sda = (i < 7) ? addr[6-i] : rw;
      wait_cyc(h - 2); m_scl = 1; wait_cyc(h); m_scl = 0;
    end
    chk("R3", "bus_busy during address", bus_busy, 1);
    wait_cyc(2); m_sda = 1; wait_cyc(h - 2); m_scl = 1;
    wait_cyc(h / 2); obs_ack = sda_oe; wait_cyc(h - h / 2); m_scl = 0;
    wait_cyc(2); m_sda = 0; wait_cyc(h - 2); m_scl = 1; wait_cyc(h); m_sda = 1;
    wait_cyc(4 * div + 8);
    -> done_ev;
    wait_cyc(2);
    clear_flags();
  endtask

  initial forever begin
    exp_t it;
    @(done_ev);
    it = exp_q.pop_front();
    chk("R5", "ack in ninth clock", obs_ack, it.ack);
    chk("R5", "oa_flag", oa_flag, it.oa);
    chk("R7", "gc_flag", gc_flag, it.gc);
    chk("R2", "start_flag", start_flag, it.st);
    chk("R9", "bus_busy after stop", bus_busy, 0);
    if (it.ack) chk("R11", "rw_dir", rw_dir, it.rw);
  end

  task automatic arm_timing();
    @(negedge clk); m_sda = 0;
    repeat (2 * div) @(posedge clk); @(negedge clk);
    chk("R2", "start_flag early", start_flag, 0);
    repeat (div) @(posedge clk); @(negedge clk);
    chk("R2", "start_flag set", start_flag, 1);
    repeat (3 * div) @(posedge clk); @(negedge clk);
    chk("R1", "bus_busy before arm", bus_busy, 0);
    chk("R3", "bus_busy before arm", bus_busy, 0);
    repeat (div) @(posedge clk); @(negedge clk);
    chk("R3", "bus_busy after arm", bus_busy, 1);
    m_sda = 1; wait_cyc(4 * div + 2);
    chk("R9", "bus_busy after stop", bus_busy, 0);
    clear_flags();
  endtask

  initial begin
    wait_cyc(3);
    chk("R9", "reset outputs", {start_flag, oa_flag, gc_flag, bus_busy, sda_oe}, 0);
    rst_n = 1; wait_cyc(2);

    cfg(8'd0, 16'hFFBA);
    arm_timing();
    txn(7'h3A, 0, 20, 10, 1, 1, 0);   // R5 R6
    txn(7'h3A, 1, 20, 10, 1, 1, 0);   // R11
    txn(7'h11, 0, 20, 10, 0, 0, 0);   // R8
    txn(7'h00, 0, 20, 10, 1, 0, 1);   // R7
    gc_en = 0;
    txn(7'h00, 0, 20, 10, 0, 0, 0);   // R7 disabled
    gc_en = 1; start_ie = 0;
    txn(7'h3A, 0, 20, 10, 1, 1, 0);   // R2 masked
    start_ie = 1;

    @(negedge clk); cfg_we = 1; cfg_oa = 16'h0055; @(negedge clk); cfg_we = 0;
    txn(7'h55, 0, 20, 10, 0, 0, 0);   // R10 write ignored
    txn(7'h3A, 0, 20, 10, 1, 1, 0);   // R10 old address kept

    @(negedge clk); flag_clr = 3'b001; m_sda = 0;
    repeat (3) @(posedge clk); @(negedge clk); flag_clr = 0;
    chk("R12", "set wins over clear", start_flag, 1);
    wait_cyc(10); m_sda = 1; wait_cyc(8);
    clear_flags();

    @(negedge clk); enable = 0; wait_cyc(2);
    chk("R10", "idle when disabled", {bus_busy, sda_oe}, 0);
    cfg(8'd3, 16'h003A);
    arm_timing();

    cfg(8'd7, 16'h003A);
    txn(7'h3A, 0, 12, 4, 0, 0, 0);    // R4 early edges lost
    txn(7'h3A, 0, 40, 70, 1, 1, 0);   // R4 slow SCL acknowledged

    wait_cyc(5);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule